// File: doc/BRIEF.md
# Serial Receive Error Status Tracker

This block holds the error and completion status of a single serial receive channel and presents it as one 8-bit status byte, together with a level-sensitive request for a special receive condition. The receive shifter, the CRC engine and the flag detector sit outside the block. They report each received character as a one-cycle event that carries its flags: framing error, parity mismatch, CRC mismatch, overrun, closing flag and residue length. Software selects the line mode as asynchronous, synchronous or bit-oriented framed (SDLC), and clears the sticky errors with an error-reset strobe.

Some status bits describe only the most recent character and are rewritten by every new one. Others stay set until an error reset clears them. While an overrun or parity error is held, the interrupt request stays asserted for every later character. Both a hardware reset and a channel reset put the byte into its idle value.

Top module: `rx_status_tracker`

## Requirements
- R1: Hardware reset (`rst`) and channel reset (`chan_rst`) each take effect at a clock edge. Afterwards the status byte reads 0x01, with only bit 0 set, and `sr_irq` is 0.
- R2: In SDLC mode (`mode`=2), every received character loads bit 7 (end of frame) from its closing-flag input. A character that carries the closing flag sets the bit, and the next character without the flag clears it.
- R3: When `mode` is not 2, bit 7 reads 0. The stored end-of-frame value still exists and reappears if SDLC mode is selected again.
- R4: Bit 6 is rewritten by every received character and is never sticky. In asynchronous mode (`mode`=0) it takes the framing-error input. In any other mode it takes the CRC-mismatch input, where 1 means the CRC did not match.
- R5: Bit 5 (overrun) is set by a character flagged as overrun. It stays set across later characters until an error reset.
- R6: Bit 4 (parity) is set by a character with a parity mismatch, but only while `parity_en` is 1. It stays set until an error reset. A mismatch received while `parity_en` is 0 has no effect.
- R7: An `err_rst` pulse clears bits 7, 5 and 4 at the same clock edge. If a character in that same cycle sets one of these bits, the set wins.
- R8: Bits 3..1 hold the residue code of the last character received in SDLC mode, with the code's LSB in bit 1. Characters received in other modes leave these bits unchanged.
- R9: Bit 0 (all sent) is 1 in synchronous and SDLC modes. In asynchronous mode it follows `tx_idle`. Either way it lags its inputs by one clock.
- R10: `sr_irq` is 1 exactly when `rx_int_en` is 1 and at least one of these holds: overrun is held, parity is held, bit 7 reads 1, or the mode is asynchronous and bit 6 is 1. A CRC mismatch alone never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| chan_rst | input | 1 | Synchronous channel reset strobe |
| mode | input | 2 | Line mode: 0 asynchronous, 1 synchronous, 2 SDLC |
| parity_en | input | 1 | Parity checking enabled |
| rx_int_en | input | 1 | Receive interrupt enable |
| err_rst | input | 1 | Error-reset command strobe |
| tx_idle | input | 1 | Transmitter has shifted out all bits and its buffer is empty |
| chr_valid | input | 1 | One-cycle strobe for a received character |
| chr_framing | input | 1 | Framing error on this character |
| chr_crc_bad | input | 1 | CRC mismatch reported with this character |
| chr_parity_bad | input | 1 | Parity mismatch on this character |
| chr_overrun | input | 1 | This character was overwritten in the receive queue |
| chr_closing | input | 1 | Closing flag seen with this character |
| chr_residue | input | 3 | Residue code reported with this character |
| status | output | 8 | Status byte |
| sr_irq | output | 1 | Special receive condition request (level) |

## Verification
A fault in a sticky latch shows up as a status bit that stays set after an error reset, or that drops when the next clean character arrives. Because the interrupt request is built from the same state, it goes wrong at the same edge. A fault in the per-character fields shows up on the character right after the one that should have changed them. The mode gating can be checked by switching modes while end-of-frame and residue state is held. The one-clock lag of the all-sent bit means every fault there appears a single cycle after the mode or `tx_idle` changes.

// File: rtl/rxsts_pkg.sv
package rxsts_pkg;

    localparam int RES_W    = 3;
    localparam int STATUS_W = 5 + RES_W;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_SYNC  = 2'd1,
        MODE_SDLC  = 2'd2,
        MODE_RSVD  = 2'd3
    } rx_mode_e;

    typedef struct packed {
        logic             eof;
        logic             crc_fe;
        logic             overrun;
        logic             parity;
        logic [RES_W-1:0] residue;
        logic             all_sent;
    } status_t;

    function automatic logic [STATUS_W-1:0] pack_status(input status_t s);
        return s;
    endfunction

endpackage

// File: rtl/rxsts_err_latch.sv
module rxsts_err_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic err_rst,
    input  logic chr_valid,
    input  logic is_sdlc,
    input  logic parity_en,
    input  logic chr_parity_bad,
    input  logic chr_overrun,
    input  logic chr_closing,
    output logic eof_q,
    output logic ovr_q,
    output logic par_q
);

    always_ff @(posedge clk) begin
        if (clr) begin
            eof_q <= 1'b0;
            ovr_q <= 1'b0;
            par_q <= 1'b0;
        end else begin
            if (chr_valid && is_sdlc)
                eof_q <= chr_closing;
            else if (err_rst)
                eof_q <= 1'b0;

            if (chr_valid && chr_overrun)
                ovr_q <= 1'b1;
            else if (err_rst)
                ovr_q <= 1'b0;

            if (chr_valid && parity_en && chr_parity_bad)
                par_q <= 1'b1;
            else if (err_rst)
                par_q <= 1'b0;
        end
    end

    // R5: a held overrun survives any cycle without an error reset
    p_ovr_hold_r5: assert property (@(posedge clk) disable iff (rst || clr)
        (ovr_q && !err_rst) |=> ovr_q);

    // R6: parity mismatch with checking off cannot raise the latch
    p_par_gate_r6: assert property (@(posedge clk) disable iff (rst || clr)
        (!par_q && !parity_en) |=> !par_q);

    // R7: error reset with no competing character clears all sticky bits
    p_err_clear_r7: assert property (@(posedge clk) disable iff (rst || clr)
        (err_rst && !chr_valid) |=> (!eof_q && !ovr_q && !par_q));

endmodule

// File: rtl/rxsts_char_fields.sv
module rxsts_char_fields
    import rxsts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             chr_valid,
    input  logic             is_async,
    input  logic             is_sdlc,
    input  logic             chr_framing,
    input  logic             chr_crc_bad,
    input  logic [RES_W-1:0] chr_residue,
    output logic             crc_fe_q,
    output logic [RES_W-1:0] residue_q
);

    always_ff @(posedge clk) begin
        if (clr) begin
            crc_fe_q  <= 1'b0;
            residue_q <= '0;
        end else if (chr_valid) begin
            crc_fe_q <= is_async ? chr_framing : chr_crc_bad;
            if (is_sdlc)
                residue_q <= chr_residue;
        end
    end

    // R8: residue only moves on a character taken in SDLC mode
    p_residue_hold_r8: assert property (@(posedge clk) disable iff (rst || clr)
        !(chr_valid && is_sdlc) |=> $stable(residue_q));

    // R4: without a character the per-character bit does not change
    p_crcfe_hold_r4: assert property (@(posedge clk) disable iff (rst || clr)
        !chr_valid |=> $stable(crc_fe_q));

endmodule

// File: rtl/rxsts_tx_done.sv
module rxsts_tx_done (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic is_async,
    input  logic tx_idle,
    output logic all_sent_q
);

    always_ff @(posedge clk) begin
        if (clr)
            all_sent_q <= 1'b1;
        else
            all_sent_q <= !is_async || tx_idle;
    end

    // R9: outside asynchronous mode the flag is high one clock later
    p_sync_allsent_r9: assert property (@(posedge clk) disable iff (rst || clr)
        !is_async |=> all_sent_q);

endmodule

// File: rtl/rx_status_tracker.sv
module rx_status_tracker
    import rxsts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_rst,
    input  logic [1:0]       mode,
    input  logic             parity_en,
    input  logic             rx_int_en,
    input  logic             err_rst,
    input  logic             tx_idle,
    input  logic             chr_valid,
    input  logic             chr_framing,
    input  logic             chr_crc_bad,
    input  logic             chr_parity_bad,
    input  logic             chr_overrun,
    input  logic             chr_closing,
    input  logic [RES_W-1:0] chr_residue,
    output logic [STATUS_W-1:0] status,
    output logic             sr_irq
);

    rx_mode_e mode_e;
    logic     clr, is_async, is_sdlc;
    logic     eof_q, ovr_q, par_q, crc_fe_q, all_sent_q;
    logic [RES_W-1:0] residue_q;
    status_t  st;

    assign mode_e   = rx_mode_e'(mode);
    assign clr      = rst || chan_rst;
    assign is_async = (mode_e == MODE_ASYNC);
    assign is_sdlc  = (mode_e == MODE_SDLC);

    rxsts_err_latch u_latch (
        .clk(clk), .rst(rst), .clr(clr), .err_rst(err_rst),
        .chr_valid(chr_valid), .is_sdlc(is_sdlc), .parity_en(parity_en),
        .chr_parity_bad(chr_parity_bad), .chr_overrun(chr_overrun),
        .chr_closing(chr_closing),
        .eof_q(eof_q), .ovr_q(ovr_q), .par_q(par_q)
    );

    rxsts_char_fields u_fields (
        .clk(clk), .rst(rst), .clr(clr), .chr_valid(chr_valid),
        .is_async(is_async), .is_sdlc(is_sdlc),
        .chr_framing(chr_framing), .chr_crc_bad(chr_crc_bad),
        .chr_residue(chr_residue),
        .crc_fe_q(crc_fe_q), .residue_q(residue_q)
    );

    rxsts_tx_done u_txdone (
        .clk(clk), .rst(rst), .clr(clr), .is_async(is_async),
        .tx_idle(tx_idle), .all_sent_q(all_sent_q)
    );

    always_comb begin
        st.eof      = eof_q && is_sdlc;
        st.crc_fe   = crc_fe_q;
        st.overrun  = ovr_q;
        st.parity   = par_q;
        st.residue  = residue_q;
        st.all_sent = all_sent_q;
    end

    assign status = pack_status(st);
    assign sr_irq = rx_int_en && (ovr_q || par_q || st.eof || (is_async && crc_fe_q));

    // R1: channel reset leaves the idle status byte
    p_chan_reset_r1: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> (status == STATUS_W'(1) && !sr_irq));

    // R3: end-of-frame is never visible outside SDLC mode
    p_eof_hidden_r3: assert property (@(posedge clk) disable iff (rst)
        !is_sdlc |-> !status[STATUS_W-1]);

    // R10: no request without the enable
    p_irq_enable_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_int_en |-> !sr_irq);

endmodule

// File: tb/rx_status_tracker_tb.sv
module rx_status_tracker_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, chan_rst, parity_en, rx_int_en, err_rst, tx_idle;
    logic [1:0] mode;
    logic       chr_valid, chr_framing, chr_crc_bad, chr_parity_bad;
    logic       chr_overrun, chr_closing;
    logic [2:0] chr_residue;
    logic [7:0] status;
    logic       sr_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_status_tracker u_dut (
        .clk(clk), .rst(rst), .chan_rst(chan_rst), .mode(mode),
        .parity_en(parity_en), .rx_int_en(rx_int_en), .err_rst(err_rst),
        .tx_idle(tx_idle), .chr_valid(chr_valid), .chr_framing(chr_framing),
        .chr_crc_bad(chr_crc_bad), .chr_parity_bad(chr_parity_bad),
        .chr_overrun(chr_overrun), .chr_closing(chr_closing),
        .chr_residue(chr_residue), .status(status), .sr_irq(sr_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_chr();
        chr_valid = 0; chr_framing = 0; chr_crc_bad = 0; chr_parity_bad = 0;
        chr_overrun = 0; chr_closing = 0; chr_residue = 3'b000;
    endtask

    // drives one character for one cycle, returns at the negedge after it is taken
    task automatic send(input logic fr, input logic crc, input logic par,
                        input logic ovr, input logic cls, input logic [2:0] res);
        chr_valid = 1; chr_framing = fr; chr_crc_bad = crc; chr_parity_bad = par;
        chr_overrun = ovr; chr_closing = cls; chr_residue = res;
        step();
        clear_chr();
    endtask

    task automatic pulse_err_rst();
        err_rst = 1;
        step();
        err_rst = 0;
    endtask

    task automatic do_reset();
        mode = 2'd0; parity_en = 1; rx_int_en = 1; tx_idle = 1;
        err_rst = 0; chan_rst = 0; clear_chr();
        rst = 1;
        step(); step();
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 hw reset status", status, 8'h01);
        chk("R1 hw reset irq", {7'b0, sr_irq}, 8'h00);
        send(0, 0, 1, 1, 0, 3'b000);
        chk("R1 errors before channel reset", status, 8'h31);
        chan_rst = 1;
        step();
        chan_rst = 0;
        chk("R1 channel reset status", status, 8'h01);
        chk("R1 channel reset irq", {7'b0, sr_irq}, 8'h00);
    endtask

    task automatic t_bit6();
        do_reset();
        send(1, 0, 0, 0, 0, 3'b000);
        chk("R4 async framing bit", status, 8'h41);
        chk("R10 framing raises irq", {7'b0, sr_irq}, 8'h01);
        send(0, 1, 0, 0, 0, 3'b000);
        chk("R4 async ignores crc, bit rewritten", status, 8'h01);
        chk("R10 irq drops with clean char", {7'b0, sr_irq}, 8'h00);
        mode = 2'd1;
        step();
        send(0, 1, 0, 0, 0, 3'b000);
        chk("R4 sync crc mismatch", status, 8'h41);
        chk("R10 crc mismatch no irq", {7'b0, sr_irq}, 8'h00);
        send(1, 0, 0, 0, 0, 3'b000);
        chk("R4 sync ignores framing", status, 8'h01);
    endtask

    task automatic t_eof();
        do_reset();
        mode = 2'd2;
        step();
        send(0, 0, 0, 0, 1, 3'b101);
        chk("R2 R8 eof with residue", status, 8'h8B);
        chk("R10 eof raises irq", {7'b0, sr_irq}, 8'h01);
        send(0, 0, 0, 0, 0, 3'b000);
        chk("R2 next char clears eof", status, 8'h01);
        send(0, 0, 0, 0, 1, 3'b010);
        chk("R2 eof again", status, 8'h85);
        mode = 2'd0;
        step();
        chk("R3 eof hidden in async", status, 8'h05);
        chk("R3 hidden eof no irq", {7'b0, sr_irq}, 8'h00);
        send(0, 0, 0, 0, 0, 3'b111);
        chk("R8 async char keeps residue", status, 8'h05);
        mode = 2'd2;
        step();
        chk("R3 stored eof reappears", status, 8'h85);
        pulse_err_rst();
        chk("R7 err reset clears eof", status, 8'h05);
    endtask

    task automatic t_overrun();
        do_reset();
        send(0, 0, 0, 1, 0, 3'b000);
        chk("R5 overrun set", status, 8'h21);
        chk("R10 overrun irq", {7'b0, sr_irq}, 8'h01);
        send(0, 0, 0, 0, 0, 3'b000);
        chk("R5 overrun held over clean char", status, 8'h21);
        chk("R10 overrun irq persists", {7'b0, sr_irq}, 8'h01);
        rx_int_en = 0;
        step();
        chk("R10 irq masked by enable", {7'b0, sr_irq}, 8'h00);
        rx_int_en = 1;
        pulse_err_rst();
        chk("R7 err reset clears overrun", status, 8'h01);
        chk("R10 irq gone after err reset", {7'b0, sr_irq}, 8'h00);
    endtask

    task automatic t_parity();
        do_reset();
        parity_en = 0;
        send(0, 0, 1, 0, 0, 3'b000);
        chk("R6 parity ignored when disabled", status, 8'h01);
        parity_en = 1;
        send(0, 0, 1, 0, 0, 3'b000);
        chk("R6 parity set", status, 8'h11);
        send(0, 0, 0, 0, 0, 3'b000);
        chk("R6 parity held", status, 8'h11);
        pulse_err_rst();
        chk("R7 err reset clears parity", status, 8'h01);
    endtask

    task automatic t_collision();
        do_reset();
        send(0, 0, 0, 1, 0, 3'b000);
        err_rst = 1;
        send(0, 0, 1, 0, 0, 3'b000);
        err_rst = 0;
        chk("R7 clear overrun, new parity wins", status, 8'h11);
        err_rst = 1;
        send(0, 0, 0, 1, 0, 3'b000);
        err_rst = 0;
        chk("R7 new overrun wins over clear", status, 8'h21);
        pulse_err_rst();
        chk("R7 plain err reset", status, 8'h01);
    endtask

    task automatic t_allsent();
        do_reset();
        tx_idle = 0;
        chk("R9 lag of one clock", status, 8'h01);
        step();
        chk("R9 async busy", status, 8'h00);
        tx_idle = 1;
        step();
        chk("R9 async idle", status, 8'h01);
        tx_idle = 0;
        mode = 2'd1;
        step();
        chk("R9 sync forces all sent", status, 8'h01);
        mode = 2'd2;
        step();
        chk("R9 sdlc forces all sent", status, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_bit6();
        t_eof();
        t_overrun();
        t_parity();
        t_collision();
        t_allsent();
        finish_run();
    end

endmodule